// File: doc/BRIEF.md
# Serial-Written Converter Control Register

This block is the write-only control register of a serial data converter. A host shifts 16-bit frames into it one bit at a time, most significant bit first. The two top bits of each frame are an address. When both are 1, the remaining 14 bits are loaded as the converter's configuration and action bits. A frame with any other address is meant for another register and leaves this one untouched.

The stored fields drive the rest of the converter through plain output pins: input mode, channel, power mode, read selection, interface mode, and calibration mode and selection. Two action bits request work. A conversion-start bit and a start-calibration bit each emit a one-cycle start pulse and then hold a busy flag. The flag drops when the matching done input arrives. The interface-mode bit clears itself whenever a read cycle ends.

When a frame is written with the start-calibration bit at 0, the calibration-select bits do not pick a calibration type. They address a calibration coefficient register, and the block marks that write with a one-cycle strobe.

The bit input is a valid/ready stream. A bit is taken on every cycle in which `in_valid`, `in_ready` and `frame_sel` are all high. `in_ready` is low during reset and high at all other times, so the host never sees back-pressure after reset. When `frame_sel` is low, any partly received frame is discarded.

Top module: `cvt_ctrl_reg`

## Requirements
- R1: During reset and after it, until the first write, every configuration output, both busy flags, both start pulses and the coefficient strobe are 0.
- R2: A frame is 16 bits, most significant bit first. It is committed on the clock edge that takes its 16th bit, and only when frame bits 15:14 are both 1. Its outputs show from the next cycle. The payload layout is as follows. Bit 13 is `in_single_ended` (0 = pseudo-differential, 1 = single-ended). Bits 12:10 are `chan_sel`, bits 9:8 are `pwr_mode` and bits 7:6 are `rd_sel`. Bit 5 is `two_wire` (1 = two-wire mode, 0 = separate lines). Bit 4 is conversion start and bit 3 is `cal_system` (0 = self, 1 = system). Bits 2:1 are `cal_sel` and bit 0 is start-calibration.
- R3: A complete frame whose bits 15:14 are not both 1 changes no output and produces no pulse.
- R4: A committed write with bit 4 = 1 while no conversion is busy raises `conv_start` for exactly one cycle, in the cycle after the commit. It also sets `conv_busy`, which stays 1 until a cycle with `conv_done` high and drops in the next cycle. `conv_done` while idle has no effect.
- R5: A committed write with bit 0 = 1 while no calibration is busy raises `cal_start` for exactly one cycle and sets `cal_busy`. `cal_busy` stays 1 until `cal_done` and drops in the next cycle.
- R6: A start bit written while its action is busy gives no pulse and leaves the busy flag set. All other fields of that frame are still loaded.
- R7: When a done input and a committing write fall in the same cycle, the done is applied first and the write afterwards. A start bit in that write therefore begins a new action, with a pulse.
- R8: `read_done` clears `two_wire` in the next cycle. If a committing write falls in the same cycle, the written value of bit 5 is kept.
- R9: A committed write with bit 0 = 0 while calibration is not busy raises `cal_coef_strobe` for one cycle. In that cycle `cal_sel` holds the written coefficient address. A write during a busy calibration gives no strobe.
- R10: Dropping `frame_sel` discards the bits of a partly received frame. The next frame is counted from its first bit.
- R11: `in_ready` is 0 while reset is asserted and 1 in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sel | input | 1 | High while a frame is being sent; low discards a partial frame |
| in_valid | input | 1 | Serial bit valid |
| in_bit | input | 1 | Serial data bit, MSB first |
| in_ready | output | 1 | Bit accepted when high with in_valid |
| conv_done | input | 1 | Conversion finished strobe |
| cal_done | input | 1 | Calibration finished strobe |
| read_done | input | 1 | Read cycle finished strobe |
| in_single_ended | output | 1 | 1 = single-ended inputs, 0 = pseudo-differential |
| chan_sel | output | 3 | Channel or channel pair |
| pwr_mode | output | 2 | Power management code |
| rd_sel | output | 2 | Register returned by the next read |
| two_wire | output | 1 | Two-wire interface mode |
| cal_system | output | 1 | 1 = system calibration, 0 = self |
| cal_sel | output | 2 | Calibration type or coefficient address |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_busy | output | 1 | Conversion in progress |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_busy | output | 1 | Calibration in progress |
| cal_coef_strobe | output | 1 | One-cycle strobe for a coefficient-address write |

## Verification
The bench attacks ordering collisions: a done input in the same cycle as a restarting write, and a read end in the same cycle as a two-wire write. A design that applied the write before the done would lose the new start or clear the fresh two-wire bit. It also sends start bits while an action is busy. A design that restarted there would pulse twice, and one that dropped the whole frame would miss the updated channel. Frames with each of the three foreign addresses, and a partial frame cut off by `frame_sel`, expose decoders that ignore the address or counters that carry stale bits into the next frame.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = FRAME_W - ADDR_W;
  localparam int NUM_ACT = 2;
  localparam int ACT_CONV = 0;
  localparam int ACT_CAL  = 1;

  // payload bit positions (decoded by the converter core)
  localparam int B_SE    = 13;
  localparam int B_CH_HI = 12;
  localparam int B_PM_HI = 9;
  localparam int B_RD_HI = 7;
  localparam int B_TW    = 5;
  localparam int B_CONV  = 4;
  localparam int B_CALMD = 3;
  localparam int B_CS_HI = 2;
  localparam int B_STCAL = 0;

  typedef struct packed {
    logic       se;
    logic [2:0] ch;
    logic [1:0] pm;
    logic [1:0] rd;
    logic       tw;
    logic       calmd;
    logic [1:0] cs;
  } cfg_t;
endpackage

// File: rtl/cvt_frame_rx.sv
module cvt_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_sel,
  input  logic               in_valid,
  input  logic               in_bit,
  output logic               in_ready,
  output logic               commit,
  output logic [FRAME_W-1:0] frame
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic               rdy_q;
  logic               accept;

  assign in_ready = rdy_q;
  assign accept   = in_valid & rdy_q & frame_sel;
  assign commit   = accept & (cnt_q == LAST);
  assign frame    = {sh_q, in_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (!frame_sel) begin
        cnt_q <= '0;
      end else if (accept) begin
        sh_q  <= {sh_q[FRAME_W-3:0], in_bit};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvt_action_bit.sv
module cvt_action_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic req,
  input  logic done,
  output logic busy,
  output logic pulse,
  output logic idle_now
);
  logic busy_q, pulse_q, start;

  // done is applied before the write of the same cycle
  assign idle_now = ~busy_q | done;
  assign start    = wr & req & idle_now;
  assign busy     = busy_q;
  assign pulse    = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      busy_q  <= (busy_q & ~done) | start;
      pulse_q <= start;
    end
  end
endmodule

// File: rtl/cvt_cfg_reg.sv
module cvt_cfg_reg
  import cvt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  cfg_t wdata,
  input  logic read_done,
  output cfg_t cfg
);
  cfg_t cfg_q;
  assign cfg = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q <= wdata;
    end else if (read_done) begin
      cfg_q.tw <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
  import cvt_pkg::*;
#(
  parameter int P_FRAME_W = FRAME_W,
  parameter int P_ADDR_W  = ADDR_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_sel,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  input  logic       conv_done,
  input  logic       cal_done,
  input  logic       read_done,
  output logic       in_single_ended,
  output logic [2:0] chan_sel,
  output logic [1:0] pwr_mode,
  output logic [1:0] rd_sel,
  output logic       two_wire,
  output logic       cal_system,
  output logic [1:0] cal_sel,
  output logic       conv_start,
  output logic       conv_busy,
  output logic       cal_start,
  output logic       cal_busy,
  output logic       cal_coef_strobe
);
  localparam int P_DATA_W = P_FRAME_W - P_ADDR_W;

  logic                 commit, wr;
  logic [P_FRAME_W-1:0] frame;
  logic [P_DATA_W-1:0]  pay;
  logic [NUM_ACT-1:0]   act_req, act_done, act_busy, act_pulse, act_idle;
  cfg_t                 wcfg, cfg;
  logic                 strobe_q;

  cvt_frame_rx #(.FRAME_W(P_FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .frame_sel(frame_sel), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .commit(commit), .frame(frame)
  );

  assign wr  = commit & (&frame[P_FRAME_W-1 -: P_ADDR_W]);
  assign pay = frame[P_DATA_W-1:0];

  assign wcfg.se    = pay[B_SE];
  assign wcfg.ch    = pay[B_CH_HI -: 3];
  assign wcfg.pm    = pay[B_PM_HI -: 2];
  assign wcfg.rd    = pay[B_RD_HI -: 2];
  assign wcfg.tw    = pay[B_TW];
  assign wcfg.calmd = pay[B_CALMD];
  assign wcfg.cs    = pay[B_CS_HI -: 2];

  cvt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(wr), .wdata(wcfg),
    .read_done(read_done), .cfg(cfg)
  );

  assign act_req[ACT_CONV]  = pay[B_CONV];
  assign act_req[ACT_CAL]   = pay[B_STCAL];
  assign act_done[ACT_CONV] = conv_done;
  assign act_done[ACT_CAL]  = cal_done;

  for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
    cvt_action_bit u_act (
      .clk(clk), .rst(rst), .wr(wr), .req(act_req[i]), .done(act_done[i]),
      .busy(act_busy[i]), .pulse(act_pulse[i]), .idle_now(act_idle[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= wr & ~pay[B_STCAL] & act_idle[ACT_CAL];
  end

  assign in_single_ended = cfg.se;
  assign chan_sel        = cfg.ch;
  assign pwr_mode        = cfg.pm;
  assign rd_sel          = cfg.rd;
  assign two_wire        = cfg.tw;
  assign cal_system      = cfg.calmd;
  assign cal_sel         = cfg.cs;
  assign conv_start      = act_pulse[ACT_CONV];
  assign conv_busy       = act_busy[ACT_CONV];
  assign cal_start       = act_pulse[ACT_CAL];
  assign cal_busy        = act_busy[ACT_CAL];
  assign cal_coef_strobe = strobe_q;
endmodule

// File: rtl/cvt_ctrl_reg_chk.sv
module cvt_ctrl_reg_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic conv_done,
  input logic cal_done,
  input logic conv_start,
  input logic conv_busy,
  input logic cal_start,
  input logic cal_busy,
  input logic cal_coef_strobe
);
  assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);
  assert_conv_pulse_one_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  assert_conv_pulse_busy_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_busy);
  assert_conv_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && !conv_done) |=> (conv_busy && !conv_start));
  assert_cal_pulse_one_R5: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);
  assert_cal_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && !cal_done) |=> (cal_busy && !cal_start));
  assert_strobe_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cal_coef_strobe |-> (!cal_busy && !cal_start));
endmodule

bind cvt_ctrl_reg cvt_ctrl_reg_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .conv_done(conv_done),
  .cal_done(cal_done), .conv_start(conv_start), .conv_busy(conv_busy),
  .cal_start(cal_start), .cal_busy(cal_busy), .cal_coef_strobe(cal_coef_strobe)
);

// File: tb/tb_cvt_ctrl_reg.sv
`timescale 1ns/1ps
module tb_cvt_ctrl_reg;
  logic clk = 0, rst = 1;
  logic frame_sel = 0, in_valid = 0, in_bit = 0;
  logic conv_done = 0, cal_done = 0, read_done = 0;
  logic in_ready, in_single_ended, two_wire, cal_system;
  logic [2:0] chan_sel;
  logic [1:0] pwr_mode, rd_sel, cal_sel;
  logic conv_start, conv_busy, cal_start, cal_busy, cal_coef_strobe;

  always #2.5 clk = ~clk;

  cvt_ctrl_reg dut (.*);

  int checks = 0, errors = 0;
  logic [16:0] qe[$];
  string       qt[$];

  // model state
  logic m_se, m_tw, m_cm; logic [2:0] m_ch; logic [1:0] m_pm, m_rd, m_cs;
  logic m_cb, m_kb, m_cp, m_kp, m_st;

  function automatic logic [16:0] got_vec();
    return {in_single_ended, chan_sel, pwr_mode, rd_sel, two_wire, cal_system,
            cal_sel, conv_start, conv_busy, cal_start, cal_busy, cal_coef_strobe};
  endfunction
  function automatic logic [16:0] exp_vec();
    return {m_se, m_ch, m_pm, m_rd, m_tw, m_cm, m_cs, m_cp, m_cb, m_kp, m_kb, m_st};
  endfunction

  task automatic check(string tag, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [1:0] a, logic se, logic [2:0] ch,
      logic [1:0] pm, logic [1:0] rd, logic tw, logic cv, logic cm,
      logic [1:0] cs, logic stc);
    return {a, se, ch, pm, rd, tw, cv, cm, cs, stc};
  endfunction

  // apply one clock edge to the model
  task automatic model_edge(logic wr_ok, logic [15:0] f, logic cd, logic kd, logic rdd);
    logic cidle, kidle;
    cidle = !m_cb || cd; kidle = !m_kb || kd;
    m_cb = m_cb && !cd; m_kb = m_kb && !kd;
    m_cp = 0; m_kp = 0; m_st = 0;
    if (rdd) m_tw = 0;
    if (wr_ok && f[15:14] == 2'b11) begin
      {m_se, m_ch, m_pm, m_rd, m_tw} = f[13:5];
      m_cm = f[3]; m_cs = f[2:1];
      if (f[4] && cidle) begin m_cb = 1; m_cp = 1; end
      if (f[0] && kidle) begin m_kb = 1; m_kp = 1; end
      if (!f[0] && kidle) m_st = 1;
    end
  endtask

  task automatic send(string tag, logic [15:0] f, logic cd = 0, logic kd = 0, logic rdd = 0);
    frame_sel = 1;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      in_valid = 1; in_bit = f[i];
      if (i == 0) begin conv_done = cd; cal_done = kd; read_done = rdd; end
    end
    @(posedge clk); #1;
    model_edge(1, f, cd, kd, rdd);
    qe.push_back(exp_vec()); qt.push_back(tag);
    @(negedge clk);
    in_valid = 0; conv_done = 0; cal_done = 0; read_done = 0;
    model_edge(0, '0, 0, 0, 0);
    @(negedge clk);
    check({tag, " next cycle (R4 R5 R9 pulses end)"}, got_vec(), exp_vec());
  endtask

  task automatic strobes(string tag, logic cd, logic kd, logic rdd);
    @(negedge clk);
    conv_done = cd; cal_done = kd; read_done = rdd;
    @(posedge clk); #1;
    model_edge(0, '0, cd, kd, rdd);
    qe.push_back(exp_vec()); qt.push_back(tag);
    @(negedge clk);
    conv_done = 0; cal_done = 0; read_done = 0;
  endtask

  // monitor: pops expected snapshots and compares
  always @(negedge clk) begin
    if (qe.size() > 0) check(qt.pop_front(), got_vec(), qe.pop_front());
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    {m_se, m_tw, m_cm, m_ch, m_pm, m_rd, m_cs, m_cb, m_kb, m_cp, m_kp, m_st} = '0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", got_vec(), 17'h0);
    check("R11 ready low in reset", {16'h0, in_ready}, 17'h0);
    rst = 0;
    @(negedge clk); @(negedge clk);
    check("R11 ready after reset", {16'h0, in_ready}, 17'h1);
    check("R1 outputs after reset", got_vec(), 17'h0);

    send("R2 R9 config write", mk(2'b11, 1, 3'd5, 2'd2, 2'd1, 1, 0, 1, 2'd2, 0));
    send("R3 addr 01 ignored", mk(2'b01, 0, 3'd0, 2'd0, 2'd0, 0, 1, 0, 2'd0, 1));
    send("R3 addr 10 ignored", mk(2'b10, 0, 3'd7, 2'd3, 2'd3, 0, 1, 0, 2'd1, 1));
    send("R3 addr 00 ignored", '0);
    send("R4 conv start", mk(2'b11, 0, 3'd1, 2'd0, 2'd2, 0, 1, 0, 2'd1, 0));
    send("R6 conv start while busy", mk(2'b11, 1, 3'd6, 2'd1, 2'd3, 1, 1, 0, 2'd3, 0));
    strobes("R4 conv done", 1, 0, 0);
    strobes("R4 conv done while idle", 1, 0, 0);
    send("R5 cal start", mk(2'b11, 0, 3'd2, 2'd0, 2'd0, 0, 0, 1, 2'd1, 1));
    send("R6 R9 write while cal busy", mk(2'b11, 1, 3'd4, 2'd3, 2'd1, 0, 0, 0, 2'd2, 0));
    strobes("R5 cal done", 0, 1, 0);
    send("R4 R5 both start", mk(2'b11, 0, 3'd3, 2'd1, 2'd1, 1, 1, 0, 2'd0, 1));
    send("R7 done with restart", mk(2'b11, 1, 3'd0, 2'd2, 2'd0, 1, 1, 1, 2'd3, 1), 1, 1, 0);
    strobes("R8 read done clears two_wire", 1, 1, 1);
    send("R8 set two_wire", mk(2'b11, 0, 3'd7, 2'd0, 2'd2, 1, 0, 0, 2'd1, 0));
    send("R8 read done with write", mk(2'b11, 0, 3'd7, 2'd0, 2'd2, 1, 0, 0, 2'd0, 0), 0, 0, 1);

    // R10: partial frame of ones, then frame_sel drop
    frame_sel = 1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); in_valid = 1; in_bit = 1;
    end
    @(negedge clk); in_valid = 0; frame_sel = 0;
    @(negedge clk);
    check("R10 partial frame no effect", got_vec(), exp_vec());
    send("R10 frame after abort", mk(2'b11, 1, 3'd2, 2'd1, 2'd3, 0, 0, 1, 2'd2, 0));

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule